// File: doc/BRIEF.md
# One-Shot Timeout Timer

This block is a single-register, one-shot countdown timer. One 32-bit write does both jobs: bit 31 says whether the timer is armed, and bits 26..0 give the number of device-clock ticks to wait. The `tick` input is a clock enable from a 60 MHz device clock domain. It is already qualified into the local clock, and only cycles with `tick` high advance the countdown.

When the countdown runs out, the stored register value is wiped to zero, enable flag included. At the same time a one-cycle `timeout_pulse` goes out, and a neighbouring interrupt controller latches it as its timeout source. The integrator maps this onto pending bit 16 of the top-level interrupt register.

Software cancels a pending timeout by writing any value with bit 31 clear. It restarts the timer by writing a new armed value, which replaces a countdown already in progress.

Top module: `tmo_oneshot`

## Requirements
- R1: After reset, `rd_data` reads zero and `timeout_pulse` stays low until an armed write has been followed by ticks.
- R2: A write stores all 32 bits of `wr_data`. `rd_data` returns that value from the next cycle onward, until another write or an expiry.
- R3: An armed write (bit 31 = 1) with count N in bits 26..0 expires on the N-th later cycle with `tick` high. A count of 0 or 1 expires on the first such tick, and cycles with `tick` low do not count.
- R4: An armed write while a countdown is running discards the old countdown and starts again from the new count.
- R5: A write with bit 31 = 0 stores its value and cancels any pending expiry. No pulse follows, however many ticks arrive.
- R6: On expiry, `rd_data` reads zero from the next cycle, and `timeout_pulse` is high for exactly that one cycle.
- R7: A tick in the same cycle as a write does not count toward the new countdown.
- R8: Bits 30..27 are stored and read back, but they are not part of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value: bit 31 enable, bits 26..0 count |
| rd_data | output | 32 | Current register value |
| tick | input | 1 | Device-clock tick enable |
| timeout_pulse | output | 1 | One-cycle expiry request to the interrupt controller |

## Verification
The bench targets the off-by-one edges of the countdown:
- **Counts of 0 and 1.** A design that decrements before comparing would let these wrap and run for 2^27 ticks.
- **Idle cycles between ticks.** A design that counts clocks instead of ticks would fire early.
- **A tick coinciding with the arming write.** Counting it would shorten the wait by one.

It also restarts a running countdown with a shorter count and cancels one midway. A design that kept the old counter would fire at the stale time. One that only cleared the flag in the read path would still pulse.

Finally, it writes a value with bits 30..27 set. A count field taken too wide would never expire within the run.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int unsigned TMO_DATA_W = 32;
    localparam int unsigned TMO_EN_BIT = 31;
    localparam int unsigned TMO_CNT_W  = 27;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_ARM    = 2'd1,
        CMD_CANCEL = 2'd2
    } tmo_cmd_e;
endpackage

// File: rtl/tmo_value_reg.sv
module tmo_value_reg
    import tmo_pkg::*;
#(
    parameter int unsigned DATA_W = TMO_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire,
    output logic [DATA_W-1:0] value_q
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.value = wr_data;
        end else if (expire) begin
            st_d.value = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_q = st_q.value;

    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !expire) |=> $stable(value_q)); // R2
endmodule

// File: rtl/tmo_countdown.sv
module tmo_countdown
    import tmo_pkg::*;
#(
    parameter int unsigned CNT_W = TMO_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmo_cmd_e         cmd,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             tick,
    output logic             expire,
    output logic             fire_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cd_st_t;

    cd_st_t st_d, st_q;
    logic   last_tick;

    always_comb begin
        last_tick = st_q.armed && tick && (cmd == CMD_NONE) && (st_q.cnt <= CNT_ONE);
        st_d      = st_q;
        st_d.fire = 1'b0;
        unique case (cmd)
            CMD_ARM: begin
                st_d.armed = 1'b1;
                st_d.cnt   = load_cnt;
            end
            CMD_CANCEL: begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end
            default: begin
                if (last_tick) begin
                    st_d.armed = 1'b0;
                    st_d.cnt   = '0;
                    st_d.fire  = 1'b1;
                end else if (st_q.armed && tick) begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = last_tick;
    assign fire_q = st_q.fire;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && tick && cmd == CMD_NONE && st_q.cnt > CNT_ONE)
        |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE)); // R3
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cmd == CMD_NONE) |=> $stable(st_q.cnt)); // R3
    AST_FIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ARM) |=> (st_q.armed && st_q.cnt == $past(load_cnt))); // R4
endmodule

// File: rtl/tmo_oneshot.sv
module tmo_oneshot
    import tmo_pkg::*;
#(
    parameter int unsigned DATA_W = TMO_DATA_W,
    parameter int unsigned EN_BIT = TMO_EN_BIT,
    parameter int unsigned CNT_W  = TMO_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    output logic              timeout_pulse
);
    tmo_cmd_e cmd;
    logic     expire;

    always_comb begin
        if (!wr_en) begin
            cmd = CMD_NONE;
        end else if (wr_data[EN_BIT]) begin
            cmd = CMD_ARM;
        end else begin
            cmd = CMD_CANCEL;
        end
    end

    tmo_value_reg #(.DATA_W(DATA_W)) i_value (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .expire  (expire),
        .value_q (rd_data)
    );

    tmo_countdown #(.CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_cnt (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .expire   (expire),
        .fire_q   (timeout_pulse)
    );

    AST_READ_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data))); // R2
    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (rd_data == '0)); // R6
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> !timeout_pulse); // R5
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick) |=> !timeout_pulse); // R7
    AST_PULSE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pulse) |-> $past(rd_data[EN_BIT])); // R3
endmodule

// File: tb/test_tmo_oneshot.sv
module test_tmo_oneshot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic        timeout_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    logic [31:0] m_reg = '0;
    logic [26:0] m_cnt = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmo_oneshot i_tmo_oneshot (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .timeout_pulse(timeout_pulse)
    );

    // monitor: compares every pulse against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && timeout_pulse) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R5/R6 unexpected pulse at cycle %0d (expected none)", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    bad++;
                    $display("FAIL R3 pulse at cycle %0d expected %0d", cyc, e);
                end
            end
        end
        if (rst_n && exp_q.size() != 0 && exp_q[0] < cyc) begin
            total++;
            bad++;
            $display("FAIL R3 missing pulse: got cycle %0d expected %0d", cyc, exp_q[0]);
            void'(exp_q.pop_front());
        end
    end

    task automatic check_rd(string tag);
        total++;
        if (rd_data !== m_reg) begin
            bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_reg);
        end
    endtask

    // driver: one cycle, model updated from the requirements, expected pulse pushed
    task automatic step(input logic wr, input logic [31:0] d, input logic tk, input string tag);
        wr_en = wr; wr_data = d; tick = tk;
        if (wr) begin
            m_reg = d; m_cnt = d[26:0];           // R7: tick ignored
        end else if (tk && m_reg[31]) begin
            if (m_cnt <= 27'd1) begin
                m_reg = '0; m_cnt = '0;
                exp_q.push_back(cyc + 1);
            end else begin
                m_cnt = m_cnt - 27'd1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; tick = 1'b0;
        check_rd(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, tag);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired (expected completion)");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_rd("R1");
        total++;
        if (timeout_pulse !== 1'b0) begin
            bad++; $display("FAIL R1 pulse actual=%b expected=0", timeout_pulse);
        end
        ticks(3, "R1");

        step(1'b1, 32'h8000_0005, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) begin
            step(1'b0, '0, 1'b1, "R3");
            step(1'b0, '0, 1'b0, "R6");
        end

        step(1'b1, 32'h8000_0000, 1'b0, "R3");
        ticks(1, "R3");
        step(1'b1, 32'h8000_0001, 1'b0, "R3");
        ticks(1, "R3");

        step(1'b1, 32'h8000_000A, 1'b0, "R4");
        ticks(4, "R4");
        step(1'b1, 32'h8000_0003, 1'b0, "R4");
        ticks(3, "R4");

        step(1'b1, 32'h8000_0004, 1'b0, "R5");
        ticks(2, "R5");
        step(1'b1, 32'h0000_0002, 1'b0, "R5");
        ticks(10, "R5");

        step(1'b1, 32'h8000_0002, 1'b1, "R7");
        ticks(2, "R7");
        step(1'b1, 32'h8000_0000, 1'b1, "R7");
        ticks(1, "R7");

        step(1'b1, 32'hF800_0002, 1'b0, "R8");
        ticks(2, "R8");

        step(1'b1, 32'h8000_0100, 1'b0, "R3");
        ticks(257, "R3");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++; $display("FAIL R3 pending pulses actual=%0d expected=0", exp_q.size());
        end
        summary();
    end
endmodule